// File: doc/BRIEF.md
# Edge-Kicked Watchdog Reset Supervisor

This block supervises a host processor through a single kick line. A free-running window counter runs while the system is out of reset. Each level change on the kick line restarts it, rising or falling alike. If a full window passes with no level change, the block drives its reset line for a fixed number of clock cycles. It then starts a fresh window, so the host gets a complete time-out period after it leaves reset.

Two digital flags stand in for analog conditions. The float flag marks the kick line as undriven: while it is high, the block kicks itself every cycle and never times out. The supply-good flag forces reset while it is low. When it returns high, reset stays asserted for one more full pulse. Reset also runs for one full pulse after the asynchronous power-on reset is released. The polarity of the reset line is chosen by a parameter.

The kick line is asynchronous to the clock and passes through a synchronizer before edge detection. The float and supply-good flags are taken as synchronous to the clock.

Top module: `kick_watchdog`

## Requirements
- R1: The kick input passes through a two-flop synchronizer. A level change on it, in either direction, restarts the window counter from zero. The restart happens on the third rising clock edge after the input changes, counting the edge that first samples the new level.
- R2: When the window counter has run TIMEOUT_CYCLES edges since its last restart with no kick, reset asserts on the next edge. After arming, reset therefore stays released for exactly TIMEOUT_CYCLES cycles when no kick arrives.
- R3: A time-out reset stays asserted for exactly PULSE_CYCLES cycles.
- R4: When a reset pulse ends, the window counter starts from zero, so a full TIMEOUT_CYCLES window follows.
- R5: While the float flag is high and reset is released, the block restarts its own window every cycle, so no time-out reset occurs. When the flag drops, a full window starts from the last restart.
- R6: With ACTIVE_HIGH = 1 the reset output is 1 when asserted. With ACTIVE_HIGH = 0 it is 0 when asserted.
- R7: Reset asserts on the first clock edge that samples the supply-good flag low and stays asserted while the flag is low. After the first edge that samples the flag high again, reset is held for PULSE_CYCLES more cycles.
- R8: Kick transitions that reach the edge detector while reset is asserted have no effect. They neither shorten nor lengthen the pulse, and the window still starts from zero when reset releases.
- R9: While power-on reset is low, the reset output is asserted. After power-on reset is released, the output stays asserted for PULSE_CYCLES cycles and then arms the window.
- R10: A kick edge that is detected in the last cycle of the window, while the counter holds TIMEOUT_CYCLES-1, prevents the time-out and restarts a full window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| kickIn | input | 1 | Kick line from the host, asynchronous; any level change restarts the window |
| kickFloat | input | 1 | High when the kick line is undriven; holds the watchdog satisfied |
| supplyOk | input | 1 | Supply-good flag, synchronous; low forces reset |
| resetOut | output | 1 | Reset line to the host, polarity set by ACTIVE_HIGH |

## Verification
The checker verifies the following on every clock edge:
- a detected kick in the armed state clears the counter without asserting reset;
- an unkicked last window cycle leads to reset;
- the float flag keeps reset released;
- a low supply flag asserts reset;
- a detected kick during a pulse leaves reset asserted;
- the counter reads zero whenever reset releases.

Exact pulse and window lengths, the last-cycle versus one-cycle-late kick boundary and the power-on sequence need whole scenarios, so only the bench can show them. The same applies to the extra pulse after the supply returns and to the inverted output of the opposite-polarity instance. The bench measures these lengths at the ports and compares every cycle against a cycle-level reference model.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  typedef enum logic [1:0] {
    ST_ARMED  = 2'd0,
    ST_PULSE  = 2'd1,
    ST_SUPLOW = 2'd2
  } kwdState_e;

  typedef struct packed {
    logic wdClear;
    logic wdRun;
    logic pulseClear;
    logic pulseRun;
  } kwdStrobe_t;

endpackage

// File: rtl/kwd_datapath.sv
module kwd_datapath
  import kwd_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1000,
  parameter int PULSE_CYCLES   = 200,
  parameter int SYNC_STAGES    = 2,
  localparam int WD_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1,
  localparam int PC_W = (PULSE_CYCLES > 2) ? $clog2(PULSE_CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             kickIn,
  input  kwdStrobe_t       strobe,
  output logic             kickEdge,
  output logic             wdDone,
  output logic             pulseDone,
  output logic [WD_W-1:0]  wdCnt
);

  localparam logic [WD_W-1:0] WD_LAST = WD_W'(TIMEOUT_CYCLES - 1);
  localparam logic [WD_W-1:0] WD_ONE  = WD_W'(1);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PULSE_CYCLES - 1);
  localparam logic [PC_W-1:0] PC_ONE  = PC_W'(1);

  // Kick line synchronizer chain
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   kickPrev;
  logic [PC_W-1:0]        pulseCnt;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[gi] <= 1'b0;
          else       syncQ[gi] <= kickIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[gi] <= 1'b0;
          else       syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate

  // Previous synchronized level for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) kickPrev <= 1'b0;
    else       kickPrev <= syncQ[SYNC_STAGES-1];
  end

  assign kickEdge = syncQ[SYNC_STAGES-1] ^ kickPrev;

  // Window counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               wdCnt <= '0;
    else if (strobe.wdClear) wdCnt <= '0;
    else if (strobe.wdRun)   wdCnt <= wdCnt + WD_ONE;
  end

  // Pulse length counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  pulseCnt <= '0;
    else if (strobe.pulseClear) pulseCnt <= '0;
    else if (strobe.pulseRun)   pulseCnt <= pulseCnt + PC_ONE;
  end

  assign wdDone    = (wdCnt == WD_LAST);
  assign pulseDone = (pulseCnt == PC_LAST);

endmodule

// File: rtl/kwd_control.sv
module kwd_control
  import kwd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       kickEdge,
  input  logic       kickFloat,
  input  logic       supplyOk,
  input  logic       wdDone,
  input  logic       pulseDone,
  output kwdStrobe_t strobe,
  output logic       rstActive,
  output logic       isArmed
);

  kwdState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_PULSE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_ARMED: begin
        if (!supplyOk) begin
          stateD = ST_SUPLOW;
        end else if (kickEdge || kickFloat) begin
          strobe.wdClear = 1'b1;
        end else if (wdDone) begin
          stateD            = ST_PULSE;
          strobe.pulseClear = 1'b1;
        end else begin
          strobe.wdRun = 1'b1;
        end
      end
      ST_PULSE: begin
        if (!supplyOk) begin
          stateD = ST_SUPLOW;
        end else if (pulseDone) begin
          stateD         = ST_ARMED;
          strobe.wdClear = 1'b1;
        end else begin
          strobe.pulseRun = 1'b1;
        end
      end
      ST_SUPLOW: begin
        strobe.pulseClear = 1'b1;
        if (supplyOk) stateD = ST_PULSE;
      end
      default: begin
        stateD = ST_PULSE;
        strobe.pulseClear = 1'b1;
      end
    endcase
  end

  assign isArmed   = (stateQ == ST_ARMED);
  assign rstActive = !isArmed;

endmodule

// File: rtl/kick_watchdog.sv
module kick_watchdog
  import kwd_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1000,
  parameter int PULSE_CYCLES   = 200,
  parameter bit ACTIVE_HIGH    = 1'b0,
  localparam int WD_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic kickIn,
  input  logic kickFloat,
  input  logic supplyOk,
  output logic resetOut
);

  kwdStrobe_t      strobe;
  logic            kickEdge;
  logic            wdDone;
  logic            pulseDone;
  logic            rstActive;
  logic            isArmed;
  logic [WD_W-1:0] wdCnt;

  kwd_datapath #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .PULSE_CYCLES  (PULSE_CYCLES),
    .SYNC_STAGES   (2)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .kickIn   (kickIn),
    .strobe   (strobe),
    .kickEdge (kickEdge),
    .wdDone   (wdDone),
    .pulseDone(pulseDone),
    .wdCnt    (wdCnt)
  );

  kwd_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .kickEdge (kickEdge),
    .kickFloat(kickFloat),
    .supplyOk (supplyOk),
    .wdDone   (wdDone),
    .pulseDone(pulseDone),
    .strobe   (strobe),
    .rstActive(rstActive),
    .isArmed  (isArmed)
  );

  generate
    if (ACTIVE_HIGH) begin : g_pol_high
      assign resetOut = rstActive;
    end else begin : g_pol_low
      assign resetOut = !rstActive;
    end
  endgenerate

endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
  parameter int TIMEOUT_CYCLES = 1000,
  parameter int CNT_W          = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             isArmed,
  input logic             rstActive,
  input logic             kickEdge,
  input logic             kickFloat,
  input logic             supplyOk,
  input logic             wdDone,
  input logic             pulseDone,
  input logic [CNT_W-1:0] wdCnt
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  // R1: a detected kick while armed restarts the window
  p_kick_restart_r1: assert property (@(posedge clk) disable iff (!rstN)
    (isArmed && supplyOk && kickEdge) |=> (wdCnt == '0 && !rstActive));

  // R2: unkicked last window cycle leads to reset
  p_timeout_fires_r2: assert property (@(posedge clk) disable iff (!rstN)
    (isArmed && supplyOk && wdDone && !kickEdge && !kickFloat) |=> rstActive);

  // R2: window counter never passes its last value while armed
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    isArmed |-> (wdCnt <= CNT_LAST));

  // R4: window starts from zero when reset releases
  p_fresh_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstActive) |-> (wdCnt == '0));

  // R5: float flag keeps the watchdog satisfied
  p_float_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (isArmed && supplyOk && kickFloat) |=> !rstActive);

  // R7: supply low forces reset
  p_supply_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> rstActive);

  // R8: kicks during reset do not release it
  p_kick_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!isArmed && supplyOk && kickEdge && !pulseDone) |=> rstActive);

endmodule

bind kick_watchdog kwd_checker #(
  .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
  .CNT_W         (WD_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .isArmed  (isArmed),
  .rstActive(rstActive),
  .kickEdge (kickEdge),
  .kickFloat(kickFloat),
  .supplyOk (supplyOk),
  .wdDone   (wdDone),
  .pulseDone(pulseDone),
  .wdCnt    (wdCnt)
);

// File: tb/sim_kick_watchdog.sv
`timescale 1ns/1ps
module sim_kick_watchdog;

  localparam int T = 16;
  localparam int P = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic kickIn = 1'b0;
  logic kickFloat = 1'b0;
  logic supplyOk = 1'b1;
  logic rstLo, rstHi;

  int checks = 0;
  int errors = 0;

  // reference model state
  int ms1, ms2, mprev, mst, mwd, mpc;

  always #4 clk = ~clk;

  kick_watchdog #(.TIMEOUT_CYCLES(T), .PULSE_CYCLES(P), .ACTIVE_HIGH(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .kickIn(kickIn), .kickFloat(kickFloat),
    .supplyOk(supplyOk), .resetOut(rstLo));

  kick_watchdog #(.TIMEOUT_CYCLES(T), .PULSE_CYCLES(P), .ACTIVE_HIGH(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .kickIn(kickIn), .kickFloat(kickFloat),
    .supplyOk(supplyOk), .resetOut(rstHi));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit expAsserted();
    return (mst != 0);
  endfunction

  task automatic modelReset();
    ms1 = 0; ms2 = 0; mprev = 0; mst = 1; mwd = 0; mpc = 0;
  endtask

  task automatic modelStep(bit k, bit f, bit s);
    bit e;
    e = (ms2 != mprev);
    case (mst)
      0: begin
        if (!s) mst = 2;
        else if (e || f) mwd = 0;
        else if (mwd == T-1) begin mst = 1; mpc = 0; end
        else mwd++;
      end
      1: begin
        if (!s) mst = 2;
        else if (mpc == P-1) begin mst = 0; mwd = 0; end
        else mpc++;
      end
      default: begin
        mpc = 0;
        if (s) mst = 1;
      end
    endcase
    mprev = ms2; ms2 = ms1; ms1 = k;
  endtask

  // one cycle: drive at negedge, advance model, check at next negedge
  task automatic cyc(bit k, bit f, bit s, string req);
    kickIn = k; kickFloat = f; supplyOk = s;
    modelStep(k, f, s);
    @(negedge clk);
    check(req, rstLo, !expAsserted());
    check("R6", rstHi, expAsserted());
  endtask

  // counts intervals the low-polarity output stays in its present state
  task automatic measure(bit toggle, bit f, string req, output int cnt);
    bit startLvl;
    bit k;
    startLvl = rstLo;
    cnt = 1;
    k = kickIn;
    for (int i = 0; i < 10*T + 4*P + 50; i++) begin
      if (toggle) k = ~k;
      cyc(k, f, 1'b1, req);
      if (rstLo != startLvl) break;
      cnt++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    check("R9", rstLo, 0);
    check("R6", rstHi, 1);
    rstN = 1'b1;

    // R9 power-on pulse, R2 window, R3 pulse, R4 fresh window
    measure(1'b0, 1'b0, "R9", n); check("R9", n, P);
    measure(1'b0, 1'b0, "R2", n); check("R2", n, T);
    measure(1'b0, 1'b0, "R3", n); check("R3", n, P);
    measure(1'b0, 1'b0, "R4", n); check("R4", n, T);

    // R8: kicks toggling throughout a pulse do not change its length
    measure(1'b1, 1'b0, "R8", n); check("R8", n, P);
    measure(1'b0, 1'b0, "R8", n);
    measure(1'b0, 1'b0, "R3", n); check("R3", n, P);

    // R10: kick detected in the last window cycle
    for (int i = 1; i <= T-2; i++) cyc((i == T-2) ? ~kickIn : kickIn, 1'b0, 1'b1, "R10");
    measure(1'b0, 1'b0, "R10", n); check("R10", n, T+2);
    measure(1'b0, 1'b0, "R3", n); check("R3", n, P);

    // R2: kick one cycle late does not prevent reset
    for (int i = 1; i <= T-1; i++) cyc((i == T-1) ? ~kickIn : kickIn, 1'b0, 1'b1, "R2");
    cyc(kickIn, 1'b0, 1'b1, "R2");
    check("R2", rstLo, 0);
    measure(1'b0, 1'b0, "R8", n); check("R8", n, P);
    measure(1'b0, 1'b0, "R8", n); check("R8", n, T);

    // R5: float flag holds watchdog satisfied
    measure(1'b0, 1'b0, "R3", n); check("R3", n, P);
    for (int i = 0; i < 5*T; i++) begin
      cyc(kickIn, 1'b1, 1'b1, "R5");
      check("R5", rstLo, 1);
    end
    measure(1'b0, 1'b0, "R5", n); check("R5", n, T);

    // R7: supply drop and recovery
    measure(1'b0, 1'b0, "R3", n); check("R3", n, P);
    repeat (3) cyc(kickIn, 1'b0, 1'b1, "R7");
    cyc(kickIn, 1'b0, 1'b0, "R7");
    check("R7", rstLo, 0);
    repeat (3) cyc(kickIn, 1'b0, 1'b0, "R7");
    cyc(kickIn, 1'b0, 1'b1, "R7");
    measure(1'b0, 1'b0, "R7", n); check("R7", n, P);

    // R1 and mixed: random stimulus against the model
    for (int i = 0; i < 4000; i++) begin
      bit k, f, s;
      k = (($urandom % 100) < 9) ? ~kickIn : kickIn;
      f = (($urandom % 100) < 3);
      s = !(($urandom % 100) < 2);
      cyc(k, f, s, "R1");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule